// File: doc/BRIEF.md
# Endian-Aware External Memory Lane Steering

This block connects a 32-bit system-side access to an external static memory data bus whose width is 8, 16 or 32 bits and whose byte order is little- or big-endian. When a request is accepted, the block splits it into one, two or four external beats. For each beat it generates an external byte address and active-low byte-lane strobes. On reads, it places each returned byte into the correct byte of the assembled 32-bit word.

On writes, all four external byte lanes are driven during every beat, using active-low per-lane output enables. When the bank is narrower than 32 bits, the beat's data is copied onto the unused upper lanes so that no lane floats.

The interface is a simple start/done pair. A request is taken when `start_i` is high and the block is idle. Beats follow on consecutive cycles. `done_o` pulses in the cycle after the last beat.

Top module: `lane_steer_top`

## Requirements
- R1: The beat count is 1 when the access size (byte=1, half=2, word=4 bytes; `size_i` 0/1/2) is no larger than the bank width (`bank_width_i` 0/1/2 = 8/16/32 bits); otherwise it is the access size divided by the bank width (4 beats for a word on an 8-bit bank).
- R2: When the access size is at least the bank width, every beat asserts strobes on all lanes the bank uses. The strobe patterns are 4'b1110 for an 8-bit bank, 4'b1100 for a 16-bit bank and 4'b0000 for a 32-bit bank.
- R3: When the access is narrower than the bank, only the lanes of the addressed bytes are strobed. Byte offset b uses lane b mod W when little-endian and lane W-1-(b mod W) when big-endian. For example, a 32-bit little-endian byte at offset 2 gives 4'b1011, and a halfword at address bit 1 = 1 gives 4'b0011.
- R4: A halfword starts at offset {addr[1],0}, a word at offset 0 and a byte at addr[1:0]. The byte at offset b belongs to system byte lane b (little-endian) or 3-b (big-endian), for both read assembly and write data. Read bytes outside the access return zero.
- R5: Each beat's external address is the system word address plus the offset of its first byte rounded down to the bank width. Beats are issued in ascending address order.
- R6: During a write beat, `ext_oe_n_o` is 4'b0000. At all other times it is 4'b1111, and outside beats the strobes are 4'b1111.
- R7: During a write beat on a narrow bank, the low W lanes are copied onto the upper lanes. Low lanes that are not strobed carry zero.
- R8: `done_o` pulses for exactly one cycle, immediately after the last beat. `rdata_o` is cleared when a request is accepted and otherwise changes only on read beats.
- R9: A start request that arrives while beats are in progress is ignored. The running access completes unchanged.
- R10: During reset, `busy_o`, `beat_valid_o` and `done_o` are low, the strobes and output enables are 4'b1111, and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request strobe, taken when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| big_endian_i | input | 1 | 1 = big-endian byte order |
| bank_width_i | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit bank |
| size_i | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| addr_i | input | ADDR_W | System byte address |
| wdata_i | input | 32 | System write word |
| busy_o | output | 1 | Beats in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read word |
| beat_valid_o | output | 1 | External beat active this cycle |
| ext_addr_o | output | ADDR_W | External byte address of the beat |
| ext_strb_n_o | output | 4 | Active-low byte-lane strobes |
| ext_wdata_o | output | 32 | External write data |
| ext_oe_n_o | output | 4 | Active-low per-lane write drive enables |
| ext_rdata_i | input | 32 | External read data |

## Verification
The completion pulse of one access and the acceptance of the next request can fall in the same cycle. The bench provokes this by driving every new request in the very cycle in which it sees `done_o`, throughout a full sweep of direction, byte order, bank width, size and alignment. In that cycle `rdata_o` must still hold the previous result. The next access must then produce its own beat count, strobes, addresses and data from a cleared word. A second overlap, a request raised mid-access, is judged by checking that the beat count and the assembled word match the original request.

// File: rtl/lsteer_pkg.sv
package lsteer_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bank_w_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_sz_e;

  typedef struct packed {
    logic    big;
    bank_w_e bw;
    acc_sz_e sz;
    logic [1:0] off;
  } req_t;

  function automatic logic [2:0] width_bytes(bank_w_e bw);
    case (bw)
      BW_8:    return 3'd1;
      BW_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(acc_sz_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] beat_count(bank_w_e bw, acc_sz_e sz);
    logic [2:0] wb;
    logic [2:0] sb;
    wb = width_bytes(bw);
    sb = size_bytes(sz);
    if (sb <= wb)                     return 3'd1;
    else if (sb == 3'd4 && wb == 3'd1) return 3'd4;
    else                              return 3'd2;
  endfunction

  function automatic logic [1:0] start_off(acc_sz_e sz, logic [1:0] a);
    case (sz)
      SZ_BYTE: return a;
      SZ_HALF: return {a[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/lsteer_seq.sv
module lsteer_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] nbeats_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic [1:0] beat_o,
  output logic       last_o,
  output logic       done_o
);

  logic       busy_q, busy_d;
  logic [1:0] cnt_q, cnt_d;
  logic [2:0] nb_q;
  logic       done_q, done_d;
  logic       cnt_en;

  always_comb begin
    accept_o = start_i & ~busy_q;
    last_o   = busy_q & ({1'b0, cnt_q} == (nb_q - 3'd1));
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    cnt_en   = accept_o | busy_q;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = 2'd0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      nb_q  <= 3'd1;
    end else begin
      if (cnt_en)   cnt_q <= cnt_d;
      if (accept_o) nb_q  <= nbeats_i;
    end
  end

  assign busy_o = busy_q;
  assign beat_o = cnt_q;
  assign done_o = done_q;

  // R9: a running access keeps stepping regardless of start_i
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + 2'd1));

  // R8: the end of a run is always marked by the completion pulse
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R8: the pulse lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/lsteer_map.sv
module lsteer_map
  import lsteer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  req_t              req_i,
  input  logic [1:0]        beat_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [LANES-1:0]  strb_n_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic [LANES-1:0]  sys_en_o,
  output logic [DATA_W-1:0] sys_word_o
);

  logic [2:0]        wb, sb, step;
  logic [3:0]        first;
  logic [1:0]        b, ln, sl, aoff;
  logic [LANES-1:0]  lane_mask;
  logic [DATA_W-1:0] beat_w;

  always_comb begin
    wb        = width_bytes(req_i.bw);
    sb        = size_bytes(req_i.sz);
    step      = (wb < sb) ? wb : sb;
    first     = 4'(req_i.off) + 4'(beat_i) * 4'(step);
    lane_mask = '0;
    sys_en_o  = '0;
    sys_word_o = '0;
    beat_w    = '0;
    b         = 2'd0;
    ln        = 2'd0;
    sl        = 2'd0;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) < step) begin
        b = 2'(first + 4'(k));
        case (req_i.bw)
          BW_8:    ln = 2'd0;
          BW_16:   ln = {1'b0, b[0] ^ req_i.big};
          default: ln = req_i.big ? ~b : b;
        endcase
        sl = req_i.big ? ~b : b;
        lane_mask[ln]            = 1'b1;
        sys_en_o[sl]             = 1'b1;
        sys_word_o[8*sl +: 8]    = ext_rdata_i[8*ln +: 8];
        beat_w[8*ln +: 8]        = wdata_i[8*sl +: 8];
      end
    end
  end

  always_comb begin
    case (req_i.bw)
      BW_8:    aoff = first[1:0];
      BW_16:   aoff = {first[1], 1'b0};
      default: aoff = 2'b00;
    endcase
    ext_addr_o = base_i + ADDR_W'(aoff);
    strb_n_o   = ~lane_mask;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_rep
      always_comb begin
        case (req_i.bw)
          BW_8:    ext_wdata_o[8*g +: 8] = beat_w[7:0];
          BW_16:   ext_wdata_o[8*g +: 8] = beat_w[8*(g%2) +: 8];
          default: ext_wdata_o[8*g +: 8] = beat_w[8*g +: 8];
        endcase
      end
    end
  endgenerate

  // R2: 8-bit bank strobes only lane 0
  assert_strb_narrow8_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && req_i.bw == BW_8) |-> strb_n_o == 4'b1110);

  // R2: 16-bit bank with halfword or word uses the low pair
  assert_strb_narrow16_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && req_i.bw == BW_16 && req_i.sz != SZ_BYTE) |-> strb_n_o == 4'b1100);

  // R3: a byte access strobes exactly one lane
  assert_strb_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && req_i.sz == SZ_BYTE) |-> $countones(~strb_n_o) == 1);

  // R7: upper pair mirrors lower pair on a 16-bit bank
  assert_rep16_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && req_i.bw == BW_16) |-> ext_wdata_o[31:16] == ext_wdata_o[15:0]);

endmodule

// File: rtl/lsteer_rd_asm.sv
module lsteer_rd_asm
  import lsteer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic [LANES-1:0]  byte_en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic       en;
      logic [7:0] d;
      logic [7:0] q;
      always_comb begin
        en = clear_i | (cap_i & byte_en_i[g]);
        d  = clear_i ? 8'h00 : word_i[8*g +: 8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 8'h00;
        else if (en) q <= d;
      end
      assign rdata_o[8*g +: 8] = q;
    end
  endgenerate

  // R8: the word holds unless cleared or captured
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !cap_i) |=> $stable(rdata_o));

endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lsteer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              big_endian_i,
  input  logic [1:0]        bank_width_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [3:0]        ext_strb_n_o,
  output logic [31:0]       ext_wdata_o,
  output logic [3:0]        ext_oe_n_o,
  input  logic [31:0]       ext_rdata_i
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              accept, busy, last, done;
  logic [1:0]        beat;
  logic [2:0]        nbeats;
  req_t              req_d, req_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] m_addr;
  logic [LANES-1:0]  m_strb_n, m_sys_en;
  logic [DATA_W-1:0] m_wdata, m_sys_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    req_d.big = big_endian_i;
    req_d.bw  = bank_w_e'(bank_width_i);
    req_d.sz  = acc_sz_e'(size_i);
    req_d.off = start_off(acc_sz_e'(size_i), addr_i[1:0]);
    nbeats    = beat_count(bank_w_e'(bank_width_i), acc_sz_e'(size_i));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q   <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      req_q   <= req_d;
      wr_q    <= wr_i;
      base_q  <= {addr_i[ADDR_W-1:2], 2'b00};
      wdata_q <= wdata_i;
    end
  end

  lsteer_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .nbeats_i (nbeats),
    .accept_o (accept),
    .busy_o   (busy),
    .beat_o   (beat),
    .last_o   (last),
    .done_o   (done)
  );

  lsteer_map #(.ADDR_W(ADDR_W)) u_map (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .valid_i     (busy),
    .req_i       (req_q),
    .beat_i      (beat),
    .base_i      (base_q),
    .wdata_i     (wdata_q),
    .ext_rdata_i (ext_rdata_i),
    .ext_addr_o  (m_addr),
    .strb_n_o    (m_strb_n),
    .ext_wdata_o (m_wdata),
    .sys_en_o    (m_sys_en),
    .sys_word_o  (m_sys_word)
  );

  lsteer_rd_asm u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_i   (accept),
    .cap_i     (busy & ~wr_q),
    .byte_en_i (m_sys_en),
    .word_i    (m_sys_word),
    .rdata_o   (rdata_o)
  );

  always_comb begin
    busy_o       = busy;
    done_o       = done;
    beat_valid_o = busy;
    ext_addr_o   = m_addr;
    ext_strb_n_o = busy ? m_strb_n : 4'b1111;
    ext_oe_n_o   = (busy && wr_q) ? 4'b0000 : 4'b1111;
    ext_wdata_o  = (busy && wr_q) ? m_wdata : '0;
  end

  // R6: nothing is strobed or driven outside a beat
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !beat_valid_o |-> (ext_oe_n_o == 4'b1111 && ext_strb_n_o == 4'b1111));

  // R1: a last beat always ends the run
  assert_last_ends_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last |=> !busy_o);

endmodule

// File: tb/lane_steer_top_tb.sv
`timescale 1ns/1ps
module lane_steer_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, wr_i, big_endian_i;
  logic [1:0]  bank_width_i, size_i;
  logic [15:0] addr_i;
  logic [31:0] wdata_i;
  logic        busy_o, done_o, beat_valid_o;
  logic [31:0] rdata_o, ext_wdata_o;
  logic [15:0] ext_addr_o;
  logic [3:0]  ext_strb_n_o, ext_oe_n_o;
  logic [31:0] ext_rdata_i;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int acc_n = 0;
  int cur_w = 4;
  bit cur_big = 0;

  logic [7:0] wm [0:255];
  bit         wf [0:255];

  always #4 clk = ~clk;

  lane_steer_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
    .big_endian_i(big_endian_i), .bank_width_i(bank_width_i), .size_i(size_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .beat_valid_o(beat_valid_o), .ext_addr_o(ext_addr_o),
    .ext_strb_n_o(ext_strb_n_o), .ext_wdata_o(ext_wdata_o), .ext_oe_n_o(ext_oe_n_o),
    .ext_rdata_i(ext_rdata_i)
  );

  function automatic logic [7:0] mem_f(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic int wbytes(int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  // external memory: lane l holds byte (l) or (W-1-l) of the bank word
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      if (l < cur_w)
        ext_rdata_i[8*l +: 8] = mem_f(int'(ext_addr_o) + (cur_big ? cur_w - 1 - l : l));
      else
        ext_rdata_i[8*l +: 8] = 8'hEE;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog R8 act=%0d exp=%0d", cyc, 60000);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic do_access(input bit wr, input bit big, input int w, input int sz,
                           input int a, input bit inject);
    int W, L, N, step, so, base, j, gap, first, bb, ln, idx;
    logic [31:0] wd, expw;
    logic [3:0]  emask;
    bit seen;
    W    = wbytes(w);
    L    = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    N    = (L <= W) ? 1 : L / W;
    step = (W < L) ? W : L;
    so   = (sz == 0) ? a : (sz == 1) ? (a & 2) : 0;
    base = 64 + 4 * (acc_n % 32);
    wd   = 32'h5A3C_96E1 ^ (acc_n * 32'h0103_0507);
    acc_n++;
    for (int k = 0; k < 4; k++) wf[base + k] = 1'b0;
    cur_w = W; cur_big = big;
    start_i = 1'b1; wr_i = wr; big_endian_i = big;
    bank_width_i = 2'(w); size_i = 2'(sz);
    addr_i = 16'(base + a); wdata_i = wd;
    @(negedge clk);
    start_i = 1'b0;
    j = 0; gap = 0; seen = 0;
    for (int c = 0; c < 12; c++) begin
      if (inject) begin
        start_i = (c == 1);
        size_i = 2'd0; bank_width_i = 2'd2; addr_i = 16'(base + 3);
      end
      if (beat_valid_o) begin
        first = so + j * step;
        emask = 4'b0000;
        for (int k = 0; k < step; k++) begin
          bb = (first + k) & 3;
          ln = (W == 1) ? 0 : (W == 2) ? (big ? 1 - (bb & 1) : (bb & 1)) : (big ? 3 - bb : bb);
          emask[ln] = 1'b1;
        end
        chk(ext_strb_n_o == ~emask, (L < W) ? "R3 lane strobe" : "R2 full strobe",
            32'(ext_strb_n_o), 32'(~emask));
        chk(ext_addr_o == 16'(base + (first / W) * W), "R5 beat address",
            32'(ext_addr_o), 32'(base + (first / W) * W));
        if (wr) begin
          chk(ext_oe_n_o == 4'b0000, "R6 write enables", 32'(ext_oe_n_o), 32'h0);
          for (int l = 0; l < 4; l++) begin
            if (l >= W)
              chk(ext_wdata_o[8*l +: 8] == ext_wdata_o[8*(l % W) +: 8], "R7 copy lane",
                  32'(ext_wdata_o[8*l +: 8]), 32'(ext_wdata_o[8*(l % W) +: 8]));
            else if (ext_strb_n_o[l])
              chk(ext_wdata_o[8*l +: 8] == 8'h00, "R7 unstrobed zero",
                  32'(ext_wdata_o[8*l +: 8]), 32'h0);
            else begin
              idx = int'(ext_addr_o) + (big ? W - 1 - l : l);
              wm[idx & 255] = ext_wdata_o[8*l +: 8];
              wf[idx & 255] = 1'b1;
            end
          end
        end else begin
          chk(ext_oe_n_o == 4'b1111, "R6 read enables", 32'(ext_oe_n_o), 32'hF);
        end
        j++;
      end else if (done_o) begin
        seen = 1;
        break;
      end else begin
        gap++;
      end
      @(negedge clk);
    end
    if (inject) start_i = 1'b0;
    chk(j == N, "R1 beat count", 32'(j), 32'(N));
    chk(seen && gap == 0, "R8 done timing", 32'(gap), 32'h0);
    if (!wr) begin
      expw = 32'h0;
      for (int b = 0; b < 4; b++)
        if (b >= so && b < so + L) expw[8*(big ? 3 - b : b) +: 8] = mem_f(base + b);
      chk(rdata_o == expw, inject ? "R9 ignored start" : "R4 read word", rdata_o, expw);
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (b >= so && b < so + L)
          chk(wf[base + b] && wm[base + b] == wd[8*(big ? 3 - b : b) +: 8], "R4 write byte",
              32'(wm[base + b]), 32'(wd[8*(big ? 3 - b : b) +: 8]));
        else
          chk(!wf[base + b], "R4 untouched byte", 32'(wf[base + b]), 32'h0);
      end
    end
  endtask

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; start_i = 1'b0; wr_i = 1'b0; big_endian_i = 1'b0;
    bank_width_i = 2'd2; size_i = 2'd2; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !beat_valid_o && !done_o, "R10 reset flags",
        {29'h0, busy_o, beat_valid_o, done_o}, 32'h0);
    chk(ext_strb_n_o == 4'hF && ext_oe_n_o == 4'hF, "R10 reset lanes",
        {24'h0, ext_strb_n_o, ext_oe_n_o}, 32'hFF);
    chk(rdata_o == 32'h0, "R10 reset rdata", rdata_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // full sweep; each request is driven in the cycle its predecessor shows done
    for (int wr = 0; wr < 2; wr++)
      for (int big = 0; big < 2; big++)
        for (int w = 0; w < 3; w++)
          for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 4; a++)
              do_access(wr[0], big[0], w, sz, a, 1'b0);

    // R9: restart attempts mid-access
    do_access(1'b0, 1'b0, 0, 2, 0, 1'b1);
    do_access(1'b0, 1'b1, 0, 2, 0, 1'b1);
    do_access(1'b0, 1'b1, 1, 2, 0, 1'b1);

    // R8: pulse width and hold of the read word
    do_access(1'b0, 1'b1, 1, 1, 2, 1'b0);
    held = rdata_o;
    @(negedge clk);
    chk(!done_o, "R8 single pulse", 32'(done_o), 32'h0);
    repeat (3) @(negedge clk);
    chk(rdata_o == held, "R8 hold", rdata_o, held);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule